// File: doc/BRIEF.md
# Iterative Column Radix-2 FFT Engine (8 points)

This block computes an 8-point discrete Fourier transform with the radix-2 decimation-in-time method. It does not build one column of butterflies for each stage. It holds a single column of four butterflies and runs it three times. After each pass, the results are written into a bank of feedback registers. A routing network chooses the operand pairs for the current pass, and a small coefficient ROM supplies four twiddle factors at once. Both are selected by a 2-bit stage value.

The user loads all eight complex samples in parallel and raises `start` for one cycle. The first pass works directly on the external samples, so the inputs only need to be valid in that cycle. The second pass reads the feedback registers. The third pass writes the spectrum to the output registers and raises `y_valid` for one cycle. Every butterfly halves its result with rounding, so the spectrum is the DFT divided by 8.

Top module: `fftc_iter8`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `y_valid` is 0 and every bit of `y_re` and `y_im` is 0.
- R2: A start is accepted when `start` is high at a rising edge and no transform is in flight. `y_valid` is then low after that edge and after the next edge. It is high for exactly one cycle after the third edge.
- R3: `start` has no effect while a transform is in flight or while `y_valid` is high. Such a start does not restart the computation, does not change the result, and does not produce a second `y_valid` pulse.
- R4: Every butterfly receives an upper operand a, a lower operand b and a twiddle w. It computes t = b·w as a full-precision complex product, with w in Q1.15. The upper output is (a·2^15 + t + 2^15) >> 16 and the lower output is (a·2^15 − t + 2^15) >> 16, each an arithmetic shift taken per real and imaginary part.
- R5: In the first pass, butterfly k takes a = x[rev(2k)] and b = x[rev(2k+1)], where rev reverses 3 bits. Its upper output goes to slot 2k and its lower output to slot 2k+1. In pass s = 1 and s = 2, with d = 2^s, butterfly k reads slot p = (k div d)·2d + (k mod d) as a and slot p+d as b, and writes its upper and lower outputs back to p and p+d. After pass 2, slot j is output bin j.
- R6: Butterfly k in pass s uses twiddle W^e with e = (k mod 2^s)·(4 / 2^s). The coefficients as (real, imaginary) Q1.15 pairs are W^0 = (32767, 0), W^1 = (23170, −23170), W^2 = (0, −32767) and W^3 = (−23170, −23170).
- R7: `y_re` and `y_im` change only in the cycle where `y_valid` is high. Otherwise they hold the last result.
- R8: The inputs `x_re` and `x_im` are sampled only at the edge that accepts a start. Changes to them during the rest of the transform do not affect the result.
- R9: If `start` is held high, a new transform is accepted every fourth edge, and `y_valid` pulses every fourth cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a transform on the current inputs |
| x_re | input | 8×16 | Real parts of samples 0..7, signed; element i is sample i |
| x_im | input | 8×16 | Imaginary parts of samples 0..7, signed |
| y_re | output | 8×16 | Real parts of bins 0..7, signed |
| y_im | output | 8×16 | Imaginary parts of bins 0..7, signed |
| y_valid | output | 1 | One-cycle flag marking a new spectrum on the outputs |

## Verification
A wrong stage count or a wrong select line shows at the ports within four cycles of a start. `y_valid` then arrives early, arrives late, repeats, or never comes. A routing or twiddle fault does not disturb the timing. It corrupts particular bins of the very next spectrum. Impulses at sample 0 and sample 1 expose these faults, because they make every bin a flat value or a single twiddle rotation. A feedback register that is stored at the wrong time shows either as results that depend on inputs changed after the start, or as outputs that move without a `y_valid` pulse.

// File: rtl/fftc_pkg.sv
package fftc_pkg;

    localparam int NPT  = 8;
    localparam int LOGN = $clog2(NPT);
    localparam int NBF  = NPT / 2;
    localparam int DW   = 16;
    localparam int TWW  = 16;
    localparam int SW   = $clog2(LOGN + 1);
    localparam int IW   = LOGN;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [TWW-1:0] re;
        logic signed [TWW-1:0] im;
    } twid_t;

    // distance between paired slots in pass s
    function automatic int pair_dist(int s);
        return 1 << s;
    endfunction

    // upper-operand slot for butterfly k in pass s
    function automatic int pos_lo(int s, int k);
        return (k / pair_dist(s)) * 2 * pair_dist(s) + (k % pair_dist(s));
    endfunction

    function automatic int bit_rev(int v);
        int r;
        r = 0;
        for (int i = 0; i < LOGN; i++) begin
            r = r | (((v >> i) & 1) << (LOGN - 1 - i));
        end
        return r;
    endfunction

    function automatic int tw_exp(int s, int k);
        return (k % pair_dist(s)) * (NBF / pair_dist(s));
    endfunction

    // W^e = cos - j sin, Q1.15
    function automatic twid_t twid(int e);
        twid_t t;
        case (e)
            0:       begin t.re = TWW'(32767);  t.im = TWW'(0);      end
            1:       begin t.re = TWW'(23170);  t.im = TWW'(-23170); end
            2:       begin t.re = TWW'(0);      t.im = TWW'(-32767); end
            default: begin t.re = TWW'(-23170); t.im = TWW'(-23170); end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/fftc_bfly.sv
module fftc_bfly
    import fftc_pkg::*;
(
    input  cplx_t a,
    input  cplx_t b,
    input  twid_t w,
    output cplx_t hi,
    output cplx_t lo
);
    localparam int FR = TWW - 1;
    localparam int AW = DW + TWW + 3;

    logic signed [AW-1:0] ar, ai, br, bi, wr, wi, pr, pi, rnd;

    always_comb begin
        ar  = AW'(a.re);
        ai  = AW'(a.im);
        br  = AW'(b.re);
        bi  = AW'(b.im);
        wr  = AW'(w.re);
        wi  = AW'(w.im);
        pr  = br * wr - bi * wi;
        pi  = br * wi + bi * wr;
        rnd = AW'(1) <<< FR;
        // sum/difference, halved with one rounding step
        hi.re = DW'(((ar <<< FR) + pr + rnd) >>> (FR + 1));
        hi.im = DW'(((ai <<< FR) + pi + rnd) >>> (FR + 1));
        lo.re = DW'(((ar <<< FR) - pr + rnd) >>> (FR + 1));
        lo.im = DW'(((ai <<< FR) - pi + rnd) >>> (FR + 1));
    end
endmodule

// File: rtl/fftc_twrom.sv
module fftc_twrom
    import fftc_pkg::*;
(
    input  logic [SW-1:0]        stage,
    output twid_t [NBF-1:0]      w
);
    twid_t [LOGN-1:0][NBF-1:0] tab;

    for (genvar s = 0; s < LOGN; s++) begin : g_row
        for (genvar k = 0; k < NBF; k++) begin : g_col
            assign tab[s][k] = twid(tw_exp(s, k));
        end
    end

    always_comb begin
        w = '0;
        for (int s = 0; s < LOGN; s++) begin
            if (int'(stage) == s) w = tab[s];
        end
    end
endmodule

// File: rtl/fftc_route.sv
module fftc_route
    import fftc_pkg::*;
(
    input  logic [SW-1:0]      stage,
    input  logic               isl,
    input  cplx_t [NPT-1:0]    x_c,
    input  cplx_t [NPT-1:0]    fb,
    input  cplx_t [NBF-1:0]    hi,
    input  cplx_t [NBF-1:0]    lo,
    output cplx_t [NBF-1:0]    a,
    output cplx_t [NBF-1:0]    b,
    output cplx_t [NPT-1:0]    nat
);
    logic [IW-1:0] pl, ph;

    always_comb begin
        a   = '0;
        b   = '0;
        nat = '0;
        pl  = '0;
        ph  = '0;
        for (int k = 0; k < NBF; k++) begin
            pl = IW'(pos_lo(int'(stage), k));
            ph = IW'(pos_lo(int'(stage), k) + pair_dist(int'(stage)));
            if (!isl) begin
                a[k] = x_c[IW'(bit_rev(2 * k))];
                b[k] = x_c[IW'(bit_rev(2 * k + 1))];
            end else begin
                a[k] = fb[pl];
                b[k] = fb[ph];
            end
            nat[pl] = hi[k];
            nat[ph] = lo[k];
        end
    end
endmodule

// File: rtl/fftc_iter8.sv
module fftc_iter8
    import fftc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NPT-1:0][DW-1:0] x_re,
    input  logic [NPT-1:0][DW-1:0] x_im,
    output logic [NPT-1:0][DW-1:0] y_re,
    output logic [NPT-1:0][DW-1:0] y_im,
    output logic                   y_valid
);
    typedef struct packed {
        logic [SW-1:0]   stage;
        logic            vld;
        cplx_t [NPT-1:0] fb;
        cplx_t [NPT-1:0] y;
    } state_t;

    state_t st_d, st_q;

    logic            accept, isl, osl;
    cplx_t [NPT-1:0] x_c, nat;
    cplx_t [NBF-1:0] a_v, b_v, hi_v, lo_v;
    twid_t [NBF-1:0] w_v;

    always_comb begin
        for (int i = 0; i < NPT; i++) begin
            x_c[i].re = x_re[i];
            x_c[i].im = x_im[i];
        end
    end

    assign isl    = (st_q.stage != '0);
    assign osl    = (st_q.stage == SW'(LOGN - 1));
    assign accept = start && !isl && !st_q.vld;

    fftc_route u_route (
        .stage (st_q.stage),
        .isl   (isl),
        .x_c   (x_c),
        .fb    (st_q.fb),
        .hi    (hi_v),
        .lo    (lo_v),
        .a     (a_v),
        .b     (b_v),
        .nat   (nat)
    );

    fftc_twrom u_rom (
        .stage (st_q.stage),
        .w     (w_v)
    );

    for (genvar k = 0; k < NBF; k++) begin : g_bf
        fftc_bfly u_bf (
            .a  (a_v[k]),
            .b  (b_v[k]),
            .w  (w_v[k]),
            .hi (hi_v[k]),
            .lo (lo_v[k])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (accept) begin
            st_d.stage = SW'(1);
            st_d.fb    = nat;
        end else if (isl && !osl) begin
            st_d.stage = st_q.stage + SW'(1);
            st_d.fb    = nat;
        end else if (osl) begin
            st_d.stage = '0;
            st_d.y     = nat;
            st_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NPT; i++) begin
            y_re[i] = st_q.y[i].re;
            y_im[i] = st_q.y[i].im;
        end
    end
    assign y_valid = st_q.vld;

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid);

    assert_final_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == SW'(LOGN - 1)) |=> y_valid);

    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> (st_q.stage == '0));

    assert_stage_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.stage) < LOGN);

    assert_output_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !y_valid |-> $stable(st_q.y));
endmodule

// File: tb/fftc_iter8_bench.sv
module fftc_iter8_bench;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               start;
    logic [7:0][15:0]   x_re, x_im, y_re, y_im;
    logic               y_valid;

    int errors = 0;
    int checks = 0;
    int xr[8], xi[8], er[8], ei[8];

    always #2 clk = ~clk;

    fftc_iter8 u_fftc_iter8 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_re(x_re), .x_im(x_im),
        .y_re(y_re), .y_im(y_im), .y_valid(y_valid)
    );

    function automatic int twr(int e);
        case (e) 0: return 32767; 1: return 23170; 2: return 0; default: return -23170; endcase
    endfunction
    function automatic int twi(int e);
        case (e) 0: return 0; 1: return -23170; 2: return -32767; default: return -23170; endcase
    endfunction
    function automatic int rev3(int v);
        return ((v & 1) << 2) | (v & 2) | ((v >> 2) & 1);
    endfunction

    // reference model built from R4, R5, R6
    task automatic model();
        longint fr[8], fi[8], gr[8], gi[8];
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 4; k++) begin
                int d, p, q, e;
                longint ar, ai, br, bi, pr, pim;
                d = 1 << s;
                if (s == 0) begin
                    p = 2 * k; q = 2 * k + 1;
                    ar = xr[rev3(2*k)]; ai = xi[rev3(2*k)];
                    br = xr[rev3(2*k+1)]; bi = xi[rev3(2*k+1)];
                end else begin
                    p = (k / d) * 2 * d + (k % d); q = p + d;
                    ar = fr[p]; ai = fi[p]; br = fr[q]; bi = fi[q];
                end
                e = (k % d) * (4 / d);
                pr  = br * twr(e) - bi * twi(e);
                pim = br * twi(e) + bi * twr(e);
                gr[p] = (ar * 32768 + pr + 32768) >>> 16;
                gi[p] = (ai * 32768 + pim + 32768) >>> 16;
                gr[q] = (ar * 32768 - pr + 32768) >>> 16;
                gi[q] = (ai * 32768 - pim + 32768) >>> 16;
            end
            fr = gr; fi = gi;
        end
        for (int j = 0; j < 8; j++) begin er[j] = int'(fr[j]); ei[j] = int'(fi[j]); end
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive_x();
        for (int i = 0; i < 8; i++) begin
            x_re[i] = 16'(xr[i]);
            x_im[i] = 16'(xi[i]);
        end
    endtask

    task automatic check_y(input string req);
        for (int j = 0; j < 8; j++) begin
            check(req, $sformatf("bin %0d re", j), int'($signed(y_re[j])), er[j]);
            check(req, $sformatf("bin %0d im", j), int'($signed(y_im[j])), ei[j]);
        end
    endtask

    task automatic rand_x();
        for (int i = 0; i < 8; i++) begin
            xr[i] = int'($urandom_range(32766)) - 16383;
            xi[i] = int'($urandom_range(32766)) - 16383;
        end
    endtask

    // one transform; scramble: change inputs after start (R8); poke: extra starts (R3)
    task automatic run_fft(input bit scramble, input bit poke, input string req);
        model();
        @(negedge clk); drive_x(); start = 1'b1;
        @(negedge clk); start = poke;
        if (scramble) begin
            for (int i = 0; i < 8; i++) begin
                x_re[i] = 16'($urandom); x_im[i] = 16'($urandom);
            end
        end
        check("R2", "valid after accept edge", int'(y_valid), 0);
        @(negedge clk);
        check("R2", "valid after second edge", int'(y_valid), 0);
        @(negedge clk);
        check("R2", "valid after third edge", int'(y_valid), 1);
        check_y(req);
        @(negedge clk); start = 1'b0;
        check("R2", "valid one cycle only", int'(y_valid), 0);
        if (poke) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                check("R3", "no extra valid pulse", int'(y_valid), 0);
            end
            check_y("R3");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; start = 1'b0; x_re = '0; x_im = '0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", int'(y_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", int'(y_valid), 0);
        check("R1", "y_re after reset", int'(y_re != '0), 0);
        check("R1", "y_im after reset", int'(y_im != '0), 0);

        // impulse at sample 0: flat spectrum of 1000 (R4)
        for (int i = 0; i < 8; i++) begin xr[i] = 0; xi[i] = 0; end
        xr[0] = 8000;
        run_fft(1'b0, 1'b0, "R4");
        for (int j = 0; j < 8; j++) begin
            check("R4", $sformatf("impulse bin %0d re", j), int'($signed(y_re[j])), 1000);
            check("R4", $sformatf("impulse bin %0d im", j), int'($signed(y_im[j])), 0);
        end

        // impulse at sample 1: pure twiddle rotation per bin (R5, R6)
        for (int i = 0; i < 8; i++) begin xr[i] = 0; xi[i] = 0; end
        xr[1] = 16000;
        run_fft(1'b0, 1'b0, "R5/R6");

        // hold (R7): inputs move, no start
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            x_re[c] = 16'($urandom);
            check("R7", "no valid without start", int'(y_valid), 0);
        end
        check_y("R7");

        // inputs changed during the transform (R8)
        rand_x();
        run_fft(1'b1, 1'b0, "R8");

        // starts during busy and valid cycles (R3)
        rand_x();
        run_fft(1'b0, 1'b1, "R3");

        // random spectra against the model (R4, R5, R6)
        for (int v = 0; v < 20; v++) begin
            rand_x();
            run_fft(1'b0, 1'b0, "R4/R5/R6");
        end

        // start held high: new transform every fourth edge (R9)
        rand_x();
        model();
        @(negedge clk); drive_x(); start = 1'b1;
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            check("R9", $sformatf("valid at cycle %0d", i), int'(y_valid),
                  (i == 3 || i == 7) ? 1 : 0);
            if (i == 3 || i == 7) check_y("R9");
        end
        start = 1'b0;
        repeat (5) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule